// File: doc/BRIEF.md
# Threshold Service Interrupt FIFO

A sixteen-entry, byte-wide FIFO placed between a host programmed-I/O port and a peripheral-side byte stream. A direction input selects which side fills it and which side drains it. In the forward direction the host writes and the peripheral pops. In the reverse direction the peripheral pushes and the host reads. The oldest byte is always presented on a shared head output.

A level interrupt tells the host when a burst can be serviced without re-reading status. In the forward direction it reports enough free space. In the reverse direction it reports enough held data. Both tests use one programmable 4-bit threshold. A service-busy input blocks the interrupt completely. Overflow and underflow attempts are dropped and latch an error flag. Any change of direction empties the FIFO.

Top module: `fifo_svc_irq`

## Requirements
- R1: The FIFO stores up to 16 bytes. `full_o` is high at 16 held bytes and `empty_o` is high at 0. After reset the FIFO is empty, the direction is forward and `err_o` is 0.
- R2: Bytes leave in the order they were accepted. `rdata_o` always shows the oldest held byte.
- R3: With `dir_rev_i`=0, `host_wr_i` pushes `host_wdata_i` and `per_pop_i` drains. With `dir_rev_i`=1, `per_push_i` pushes `per_wdata_i` and `host_rd_i` drains. Strobes belonging to the inactive direction have no effect and raise no error.
- R4: With `dir_rev_i`=0 and `svc_busy_i`=0, `irq_o` is 1 exactly when the held count is at most `thresh_i`. For example, threshold 12 gives 12 or fewer bytes.
- R5: With `dir_rev_i`=1 and `svc_busy_i`=0, `irq_o` is 1 exactly when the held count is at least 16 minus `thresh_i`. With threshold 0 this is full only.
- R6: While `svc_busy_i`=1, `irq_o` is 0.
- R7: A push while full and a pop while empty are dropped and set `err_o`. `err_o` stays set until reset.
- R8: A change of `dir_rev_i` empties the FIFO at the next clock edge. Strobes in that cycle are ignored and raise no error.
- R9: A push and a pop in the same cycle both take effect, and the count is unchanged. Acceptance is judged on the state at the start of the cycle. When full, the push is dropped and the pop succeeds. When empty, the pop is dropped and the push succeeds.
- R10: `irq_o`, `full_o` and `empty_o` are functions of the registered count. They change at the clock edge that updates the count, and `irq_o` follows threshold, busy and direction without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dir_rev_i | input | 1 | 0 forward (host fills), 1 reverse (peripheral fills) |
| thresh_i | input | 4 | Interrupt threshold |
| svc_busy_i | input | 1 | Service-busy bit; 1 blocks the interrupt |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 8 | Host write byte |
| host_rd_i | input | 1 | Host read strobe |
| per_push_i | input | 1 | Peripheral push strobe |
| per_wdata_i | input | 8 | Peripheral push byte |
| per_pop_i | input | 1 | Peripheral pop strobe |
| rdata_o | output | 8 | Oldest held byte |
| irq_o | output | 1 | Service interrupt level |
| full_o | output | 1 | FIFO full |
| empty_o | output | 1 | FIFO empty |
| err_o | output | 1 | Sticky overflow/underflow flag |

## Verification
A push and a pop can land in the same cycle. Each must be accepted or rejected on the state at the start of that cycle. The bench drives both strobes together in three cases: with a partly filled FIFO, with a full FIFO and with an empty FIFO. It then judges the outcome from the flags, the error bit and the byte order seen while draining. A direction flip can also coincide with a strobe. That case is judged by checking that the FIFO comes out empty with no error.

// File: rtl/fsi_pkg.sv
package fsi_pkg;
  typedef enum logic {DIR_FWD = 1'b0, DIR_REV = 1'b1} fsi_dir_e;
endpackage

// File: rtl/fsi_store.sv
module fsi_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          push_rej_o,
  output logic          pop_rej_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o     = (count_q == CW'(DEPTH));
  assign empty_o    = (count_q == '0);
  assign push_ok    = push_i & ~full_o & ~flush_i;
  assign pop_ok     = pop_i & ~empty_o & ~flush_i;
  assign push_rej_o = push_i & full_o & ~flush_i;
  assign pop_rej_o  = pop_i & empty_o & ~flush_i;
  assign rdata_o    = mem_q[rd_ptr_q];
  assign count_o    = count_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      if (push_ok && !pop_ok)      count_q <= count_q + 1'b1;
      else if (pop_ok && !push_ok) count_q <= count_q - 1'b1;
    end
  end

  // R1
  count_le_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));

  // R1
  flags_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  // R7
  full_push_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> full_o);

  // R8
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);

  // R9
  both_ops_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !full_o && !empty_o && !flush_i) |=> $stable(count_q));
endmodule

// File: rtl/fsi_irq.sv
module fsi_irq #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned TW   = $clog2(DEPTH)
) (
  input  logic          dir_rev_i,
  input  logic [TW-1:0] thresh_i,
  input  logic          svc_busy_i,
  input  logic [CW-1:0] count_i,
  output logic          irq_o
);
  logic [CW-1:0] thr_ext, need_rev;
  logic          hit;

  assign thr_ext  = CW'(thresh_i);
  assign need_rev = CW'(DEPTH) - thr_ext;
  // forward: enough free room; reverse: enough held data
  assign hit      = dir_rev_i ? (count_i >= need_rev) : (count_i <= thr_ext);
  assign irq_o    = hit & ~svc_busy_i;
endmodule

// File: rtl/fifo_svc_irq.sv
module fifo_svc_irq #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned TW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dir_rev_i,
  input  logic [TW-1:0] thresh_i,
  input  logic          svc_busy_i,
  input  logic          host_wr_i,
  input  logic [DW-1:0] host_wdata_i,
  input  logic          host_rd_i,
  input  logic          per_push_i,
  input  logic [DW-1:0] per_wdata_i,
  input  logic          per_pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          err_o
);
  import fsi_pkg::*;

  fsi_dir_e      dir_q, dir_cur;
  logic          flush, push, pop, push_rej, pop_rej, err_q;
  logic [DW-1:0] wdata;
  logic [CW-1:0] count;

  assign dir_cur = fsi_dir_e'(dir_rev_i);
  assign flush   = (dir_cur != dir_q);
  assign push    = (dir_cur == DIR_FWD) ? host_wr_i : per_push_i;
  assign pop     = (dir_cur == DIR_FWD) ? per_pop_i : host_rd_i;
  assign wdata   = (dir_cur == DIR_FWD) ? host_wdata_i : per_wdata_i;
  assign err_o   = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= DIR_FWD;
      err_q <= 1'b0;
    end else begin
      dir_q <= dir_cur;
      if (push_rej || pop_rej) err_q <= 1'b1;
    end
  end

  fsi_store #(.DEPTH(DEPTH), .DW(DW)) i_store (
    .clk_i, .rst_ni,
    .flush_i(flush), .push_i(push), .pop_i(pop), .wdata_i(wdata),
    .rdata_o, .count_o(count), .full_o, .empty_o,
    .push_rej_o(push_rej), .pop_rej_o(pop_rej)
  );

  fsi_irq #(.DEPTH(DEPTH)) i_irq (
    .dir_rev_i, .thresh_i, .svc_busy_i, .count_i(count), .irq_o
  );

  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);

  // R4
  fwd_empty_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_rev_i && !svc_busy_i && empty_o) |-> irq_o);

  // R5
  rev_zero_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_rev_i && thresh_i == '0 && irq_o) |-> full_o);

  // R6
  busy_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_busy_i |-> !irq_o);
endmodule

// File: tb/test_fifo_svc_irq.sv
module test_fifo_svc_irq;
  localparam int unsigned CLK_PERIOD = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       dir_rev_i = 1'b0, svc_busy_i = 1'b0;
  logic [3:0] thresh_i = 4'd12;
  logic       host_wr_i = 1'b0, host_rd_i = 1'b0, per_push_i = 1'b0, per_pop_i = 1'b0;
  logic [7:0] host_wdata_i = '0, per_wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o, full_o, empty_o, err_o;

  int checks = 0, failures = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fifo_svc_irq i_fifo_svc_irq (
    .clk_i, .rst_ni, .dir_rev_i, .thresh_i, .svc_busy_i,
    .host_wr_i, .host_wdata_i, .host_rd_i,
    .per_push_i, .per_wdata_i, .per_pop_i,
    .rdata_o, .irq_o, .full_o, .empty_o, .err_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic op(input logic hw, input logic hr, input logic pp, input logic po,
                    input logic [7:0] hd, input logic [7:0] pd);
    @(negedge clk_i);
    host_wr_i = hw; host_rd_i = hr; per_push_i = pp; per_pop_i = po;
    host_wdata_i = hd; per_wdata_i = pd;
    @(negedge clk_i);
    host_wr_i = 0; host_rd_i = 0; per_push_i = 0; per_pop_i = 0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0; dir_rev_i = 0; svc_busy_i = 0;
    exp_q.delete();
    @(negedge clk_i);
    rst_ni = 1;
    #1;
  endtask

  task automatic set_dir(input logic d);
    @(negedge clk_i);
    dir_rev_i = d;
    @(negedge clk_i);
    #1;
    exp_q.delete();
  endtask

  // drain via active pop side, checking order
  task automatic drain(input string tag);
    while (exp_q.size() > 0) begin
      chk(tag, rdata_o, exp_q[0]);
      void'(exp_q.pop_front());
      if (dir_rev_i) op(0, 1, 0, 0, 0, 0);
      else           op(0, 0, 0, 1, 0, 0);
    end
    chk({tag, " empty"}, empty_o, 1);
  endtask

  task automatic t_reset();
    chk("R1 reset empty", empty_o, 1);
    chk("R1 reset full", full_o, 0);
    chk("R7 reset err", err_o, 0);
    chk("R4 reset irq", irq_o, 1);
  endtask

  task automatic t_fwd_thresh();
    thresh_i = 4'd12;
    for (int i = 0; i < 12; i++) begin
      op(1, 0, 0, 0, 8'h20 + 8'(i), 0);
      exp_q.push_back(8'h20 + 8'(i));
    end
    chk("R4 fwd 12 held irq", irq_o, 1);
    op(1, 0, 0, 0, 8'h2c, 0); exp_q.push_back(8'h2c);
    chk("R4 fwd 13 held irq", irq_o, 0);
    chk("R2 fwd head", rdata_o, 8'h20);
    op(0, 0, 0, 1, 0, 0); void'(exp_q.pop_front());
    chk("R10 fwd irq after pop", irq_o, 1);
    thresh_i = 4'd3; #1;
    chk("R10 irq follows thresh", irq_o, 0);
    thresh_i = 4'd12; #1;
    drain("R2 fwd order");
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 16; i++) begin
      op(1, 0, 0, 0, 8'h40 + 8'(i), 0);
      exp_q.push_back(8'h40 + 8'(i));
    end
    chk("R1 full at 16", full_o, 1);
    chk("R7 err before", err_o, 0);
    op(1, 0, 0, 0, 8'hee, 0);
    chk("R7 overflow err", err_o, 1);
    chk("R7 still full", full_o, 1);
    drain("R7 overflow dropped");
    chk("R7 err sticky", err_o, 1);
    do_reset();
    op(0, 0, 0, 1, 0, 0);
    chk("R7 underflow err", err_o, 1);
    chk("R7 underflow empty", empty_o, 1);
    do_reset();
  endtask

  task automatic t_reverse();
    set_dir(1);
    thresh_i = 4'd4;
    op(1, 0, 0, 0, 8'h77, 0);
    chk("R3 rev host_wr ignored", empty_o, 1);
    chk("R3 rev host_wr no err", err_o, 0);
    for (int i = 0; i < 11; i++) begin
      op(0, 0, 1, 0, 0, 8'h60 + 8'(i));
      exp_q.push_back(8'h60 + 8'(i));
    end
    chk("R5 rev 11 irq", irq_o, 0);
    op(0, 0, 1, 0, 0, 8'h6b); exp_q.push_back(8'h6b);
    chk("R5 rev 12 irq", irq_o, 1);
    op(0, 0, 0, 1, 0, 0);
    chk("R3 rev per_pop ignored", irq_o, 1);
    chk("R3 rev head kept", rdata_o, 8'h60);
    svc_busy_i = 1; #1;
    chk("R6 busy masks", irq_o, 0);
    svc_busy_i = 0; #1;
    thresh_i = 4'd0; #1;
    chk("R5 thr0 not full", irq_o, 0);
    for (int i = 0; i < 4; i++) begin
      op(0, 0, 1, 0, 0, 8'h6c + 8'(i));
      exp_q.push_back(8'h6c + 8'(i));
    end
    chk("R5 thr0 full", irq_o, 1);
    chk("R1 rev full", full_o, 1);
    drain("R2 rev order");
    chk("R3 rev no err", err_o, 0);
  endtask

  task automatic t_flush();
    op(0, 0, 1, 0, 0, 8'h11);
    op(0, 0, 1, 0, 0, 8'h12);
    chk("R8 pre flush", empty_o, 0);
    @(negedge clk_i);
    dir_rev_i = 0; per_push_i = 1; host_wr_i = 1; host_wdata_i = 8'h99;
    @(negedge clk_i);
    per_push_i = 0; host_wr_i = 0; #1;
    exp_q.delete();
    chk("R8 flush empty", empty_o, 1);
    chk("R8 flush no err", err_o, 0);
    thresh_i = 4'd0; #1;
    chk("R4 fwd thr0 empty irq", irq_o, 1);
  endtask

  task automatic t_both();
    for (int i = 0; i < 5; i++) begin
      op(1, 0, 0, 0, 8'h80 + 8'(i), 0);
      exp_q.push_back(8'h80 + 8'(i));
    end
    op(1, 0, 0, 1, 8'h99, 0);
    void'(exp_q.pop_front()); exp_q.push_back(8'h99);
    chk("R9 both head", rdata_o, 8'h81);
    chk("R9 both no err", err_o, 0);
    drain("R9 both order");
    for (int i = 0; i < 16; i++) begin
      op(1, 0, 0, 0, 8'ha0 + 8'(i), 0);
      exp_q.push_back(8'ha0 + 8'(i));
    end
    op(1, 0, 0, 1, 8'hff, 0); void'(exp_q.pop_front());
    chk("R9 full both not full", full_o, 0);
    chk("R9 full both err", err_o, 1);
    drain("R9 full both order");
    do_reset();
    op(1, 0, 0, 1, 8'h5a, 0);
    chk("R9 empty both push", empty_o, 0);
    chk("R9 empty both head", rdata_o, 8'h5a);
    chk("R9 empty both err", err_o, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1; #1;
    t_reset();
    t_fwd_thresh();
    t_overflow();
    t_reverse();
    t_flush();
    t_both();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule